// File: doc/BRIEF.md
# Peripheral Command Decode and Status

This block sits inside one peripheral and turns 16-bit I/O command words into actions on that peripheral. Each command carries a 3-bit operation field and a 6-bit device code. Addressed operations run only when the code in the word matches the code the peripheral was given. Two operations are broadcast and run whatever the code: the I/O reset and the mask-out.

The I/O reset takes the peripheral's identity from the device-side pins. That identity is the device code, the data polarity and an external-register enable flag. Data moving between the command bus and the device pins is passed straight through or inverted, as the latched polarity selects.

The block keeps busy, done, interrupt-disable and interrupt-request bits. Commands change busy and done, and so do one-cycle set pulses from the peripheral. A skip command returns busy and done. A mask-out command picks the new interrupt-disable value out of the bus data word, at a bit position the peripheral supplies.

Bits are numbered 0 to 15 with bit 0 as the most significant. Every output is registered. A command presented with `cmd_valid_i` high at one rising clock edge shows its effect on the outputs after that edge.

Top module: `periph_cmd_ctl`

## Requirements
- R1: After the asynchronous reset, every output is 0. This covers busy, done, interrupt request, interrupt disable, device code, polarity, external enable, pin write strobe, pin data, response valid and response data.
- R2: The I/O reset operation (opcode 7 in `cmd_word_i[10:8]`) runs for any device code. It latches the device code from `pin_in_i[5:0]`, the polarity from `pin_in_i[15]` and the external enable from `pin_in_i[14]`, all taken as raw levels with high meaning 1. It also clears busy, done and interrupt request.
- R3: Addressed operations run only when `cmd_word_i[5:0]` equals the latched device code. These are start (1), clear (2), skip (3), data-out (4) and data-in (5). On a mismatch, status and all outputs stay unchanged.
- R4: Data-out drives `pin_out_o` with the bus word. The word passes unchanged when polarity is 1 and inverted when polarity is 0. `pin_wr_o` pulses high for exactly that one cycle.
- R5: Data-in returns `pin_in_i` on `rsp_data_o` with `rsp_valid_o` high for one cycle. The word passes unchanged when polarity is 1 and inverted when polarity is 0.
- R6: Mask-out (opcode 6, broadcast) sets interrupt disable to bus bit number `mask_idx_i`, counted with bit 0 as MSB, which is `bus_wdata_i[15-mask_idx_i]`. No other operation or input changes interrupt disable.
- R7: `set_busy_i` and `set_done_i` each set their bit. Start sets busy and clears done. Clear clears both.
- R8: When start, clear or I/O reset runs in the same cycle as a peripheral set pulse, the command's value for busy and done wins.
- R9: Skip returns busy on `rsp_data_o[15]` (bit 0) and done on `rsp_data_o[14]` (bit 1), with all other bits 0 and `rsp_valid_o` high. The values are those held before the command.
- R10: The interrupt request sets on the cycle that done rises while interrupt disable is 0. Start, clear and I/O reset clear it, and so does interrupt disable becoming 1. It is never 1 while interrupt disable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | A command word is presented this cycle |
| cmd_word_i | input | 16 | Command: [10:8] operation, [5:0] device code |
| bus_wdata_i | input | 16 | Bus data for data-out and mask-out |
| mask_idx_i | input | 4 | Bus bit number (0 = MSB) used by mask-out |
| pin_in_i | input | 16 | Device-side pin levels |
| set_busy_i | input | 1 | Peripheral pulse setting busy |
| set_done_i | input | 1 | Peripheral pulse setting done |
| pin_out_o | output | 16 | Device-side pin levels driven by data-out |
| pin_wr_o | output | 1 | One-cycle strobe for new pin data |
| rsp_valid_o | output | 1 | Response word valid (data-in or skip) |
| rsp_data_o | output | 16 | Response word |
| busy_o | output | 1 | Busy bit |
| done_o | output | 1 | Done bit |
| irq_o | output | 1 | Interrupt request |
| int_dis_o | output | 1 | Interrupt disable bit |
| ext_reg_en_o | output | 1 | Latched external-register enable |
| dev_code_o | output | 6 | Latched device code |
| polarity_o | output | 1 | Latched data polarity |

## Verification
Code matching is swept over all 64 command codes against one latched code. A start only lands on the exact match, so an off-by-one or bit-reversed compare shows up at once.

Polarity is tried in both settings. The data patterns are all zeros, all ones, mixed words and a walking one, which separates straight passing, inversion and bit reordering in both directions.

Mask-out is swept over every index against walking-one bus words. This pins the MSB-first bit numbering.

Busy/done sequences combine peripheral pulses with commands in the same cycle. They show command priority, the done-rise interrupt and its masking.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_CLEAR = 3'd2,
    OP_SKIP  = 3'd3,
    OP_DOUT  = 3'd4,
    OP_DIN   = 3'd5,
    OP_MASK  = 3'd6,
    OP_IORST = 3'd7
  } pcd_op_e;

  localparam int unsigned OP_LSB = 8;
  localparam int unsigned OP_W   = 3;
endpackage

// File: rtl/pcd_decode.sv
module pcd_decode
  import pcd_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [DATA_W-1:0] cmd_word,
  input  logic [DATA_W-1:0] pin_in,
  output logic [CODE_W-1:0] code_q,
  output logic              pol_q,
  output logic              ext_q,
  output logic              do_start,
  output logic              do_clear,
  output logic              do_skip,
  output logic              do_dout,
  output logic              do_din,
  output logic              do_mask,
  output logic              do_iorst
);
  pcd_op_e           op;
  logic              hit;
  logic [CODE_W-1:0] code_d;
  logic              pol_d;
  logic              ext_d;

  always_comb begin
    op       = pcd_op_e'(cmd_word[OP_LSB +: OP_W]);
    hit      = cmd_valid && (cmd_word[CODE_W-1:0] == code_q);
    do_start = hit && (op == OP_START);
    do_clear = hit && (op == OP_CLEAR);
    do_skip  = hit && (op == OP_SKIP);
    do_dout  = hit && (op == OP_DOUT);
    do_din   = hit && (op == OP_DIN);
    do_mask  = cmd_valid && (op == OP_MASK);
    do_iorst = cmd_valid && (op == OP_IORST);
  end

  always_comb begin
    code_d = code_q;
    pol_d  = pol_q;
    ext_d  = ext_q;
    if (do_iorst) begin
      code_d = pin_in[CODE_W-1:0];
      pol_d  = pin_in[DATA_W-1];
      ext_d  = pin_in[DATA_W-2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      pol_q  <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      pol_q  <= pol_d;
      ext_q  <= ext_d;
    end
  end

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !do_iorst |=> $stable(code_q) && $stable(pol_q) && $stable(ext_q));

  assert_addr_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_start || do_clear || do_skip || do_dout || do_din) |-> (cmd_word[CODE_W-1:0] == code_q));
endmodule

// File: rtl/pcd_status.sv
module pcd_status #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_start,
  input  logic              do_clear,
  input  logic              do_iorst,
  input  logic              do_mask,
  input  logic              set_busy,
  input  logic              set_done,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [IDX_W-1:0]  mask_idx,
  output logic              busy_q,
  output logic              done_q,
  output logic              irq_q,
  output logic              int_dis_q
);
  localparam logic [IDX_W-1:0] TOP_BIT = IDX_W'(DATA_W - 1);

  logic busy_d, done_d, irq_d, int_dis_d;
  logic wipe, done_rise, mask_bit;

  always_comb begin
    wipe     = do_clear || do_iorst;
    mask_bit = bus_wdata[TOP_BIT - mask_idx];

    busy_d = busy_q || set_busy;
    done_d = done_q || set_done;
    if (do_start) begin
      busy_d = 1'b1;
      done_d = 1'b0;
    end else if (wipe) begin
      busy_d = 1'b0;
      done_d = 1'b0;
    end

    int_dis_d = do_mask ? mask_bit : int_dis_q;
    done_rise = done_d && !done_q;
    irq_d     = (irq_q || done_rise) && !int_dis_d && !do_start && !wipe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      irq_q     <= 1'b0;
      int_dis_q <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      done_q    <= done_d;
      irq_q     <= irq_d;
      int_dis_q <= int_dis_d;
    end
  end

  assert_mask_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !do_mask |=> $stable(int_dis_q));

  assert_cmd_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (do_clear || do_iorst) |=> !busy_q && !done_q);

  assert_start_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    do_start |=> busy_q && !done_q);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> !int_dis_q);
endmodule

// File: rtl/pcd_port.sv
module pcd_port #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pol,
  input  logic              do_dout,
  input  logic              do_din,
  input  logic              do_skip,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] pin_in,
  input  logic              busy,
  input  logic              done,
  output logic              pin_wr_q,
  output logic [DATA_W-1:0] pin_out_q,
  output logic              rsp_valid_q,
  output logic [DATA_W-1:0] rsp_data_q
);
  logic [DATA_W-1:0] flip;
  logic [DATA_W-1:0] pin_out_d, rsp_data_d, skip_word;
  logic              pin_wr_d, rsp_valid_d;

  always_comb begin
    flip      = {DATA_W{~pol}};
    skip_word = '0;
    skip_word[DATA_W-1] = busy;
    skip_word[DATA_W-2] = done;

    pin_wr_d  = do_dout;
    pin_out_d = do_dout ? (bus_wdata ^ flip) : pin_out_q;

    rsp_valid_d = do_din || do_skip;
    rsp_data_d  = rsp_data_q;
    if (do_din) begin
      rsp_data_d = pin_in ^ flip;
    end else if (do_skip) begin
      rsp_data_d = skip_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_wr_q    <= 1'b0;
      pin_out_q   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      pin_wr_q    <= pin_wr_d;
      pin_out_q   <= pin_out_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_data_q  <= rsp_data_d;
    end
  end

  assert_dout_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_dout |=> pin_wr_q);

  assert_pins_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !do_dout |=> $stable(pin_out_q) && !pin_wr_q);

  assert_rsp_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_din || do_skip) |=> rsp_valid_q);
endmodule

// File: rtl/periph_cmd_ctl.sv
module periph_cmd_ctl
  import pcd_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CODE_W = 6,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [DATA_W-1:0] cmd_word_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [IDX_W-1:0]  mask_idx_i,
  input  logic [DATA_W-1:0] pin_in_i,
  input  logic              set_busy_i,
  input  logic              set_done_i,
  output logic [DATA_W-1:0] pin_out_o,
  output logic              pin_wr_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o,
  output logic              int_dis_o,
  output logic              ext_reg_en_o,
  output logic [CODE_W-1:0] dev_code_o,
  output logic              polarity_o
);
  logic do_start, do_clear, do_skip, do_dout, do_din, do_mask, do_iorst;

  pcd_decode #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid_i),
    .cmd_word (cmd_word_i),
    .pin_in   (pin_in_i),
    .code_q   (dev_code_o),
    .pol_q    (polarity_o),
    .ext_q    (ext_reg_en_o),
    .do_start (do_start),
    .do_clear (do_clear),
    .do_skip  (do_skip),
    .do_dout  (do_dout),
    .do_din   (do_din),
    .do_mask  (do_mask),
    .do_iorst (do_iorst)
  );

  pcd_status #(.DATA_W(DATA_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .do_start (do_start),
    .do_clear (do_clear),
    .do_iorst (do_iorst),
    .do_mask  (do_mask),
    .set_busy (set_busy_i),
    .set_done (set_done_i),
    .bus_wdata(bus_wdata_i),
    .mask_idx (mask_idx_i),
    .busy_q   (busy_o),
    .done_q   (done_o),
    .irq_q    (irq_o),
    .int_dis_q(int_dis_o)
  );

  pcd_port #(.DATA_W(DATA_W)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .pol        (polarity_o),
    .do_dout    (do_dout),
    .do_din     (do_din),
    .do_skip    (do_skip),
    .bus_wdata  (bus_wdata_i),
    .pin_in     (pin_in_i),
    .busy       (busy_o),
    .done       (done_o),
    .pin_wr_q   (pin_wr_o),
    .pin_out_q  (pin_out_o),
    .rsp_valid_q(rsp_valid_o),
    .rsp_data_q (rsp_data_o)
  );

  assert_one_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_start, do_clear, do_skip, do_dout, do_din, do_mask, do_iorst}));

  assert_skip_format_R9: assert property (@(posedge clk) disable iff (!rst_n)
    do_skip |=> (rsp_data_o[DATA_W-3:0] == '0));
endmodule

// File: tb/periph_cmd_ctl_tb_top.sv
`timescale 1ns/1ps
module periph_cmd_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [15:0] cmd_word_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic [3:0]  mask_idx_i = '0;
  logic [15:0] pin_in_i = '0;
  logic        set_busy_i = 1'b0;
  logic        set_done_i = 1'b0;
  logic [15:0] pin_out_o;
  logic        pin_wr_o;
  logic        rsp_valid_o;
  logic [15:0] rsp_data_o;
  logic        busy_o, done_o, irq_o, int_dis_o, ext_reg_en_o, polarity_o;
  logic [5:0]  dev_code_o;

  int checks = 0;
  int errors = 0;
  logic [5:0] cur_code = '0;

  always #2.5 clk = ~clk;

  periph_cmd_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_word_i(cmd_word_i),
    .bus_wdata_i(bus_wdata_i), .mask_idx_i(mask_idx_i), .pin_in_i(pin_in_i),
    .set_busy_i(set_busy_i), .set_done_i(set_done_i), .pin_out_o(pin_out_o),
    .pin_wr_o(pin_wr_o), .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
    .busy_o(busy_o), .done_o(done_o), .irq_o(irq_o), .int_dis_o(int_dis_o),
    .ext_reg_en_o(ext_reg_en_o), .dev_code_o(dev_code_o), .polarity_o(polarity_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle at a negedge; results are visible at the next negedge.
  task automatic step(input logic v, input logic [2:0] op, input logic [5:0] code,
                      input logic [15:0] wd, input logic [3:0] idx, input logic [15:0] pins,
                      input logic sb, input logic sd);
    cmd_valid_i = v;
    cmd_word_i  = {5'b0, op, 2'b0, code};
    bus_wdata_i = wd;
    mask_idx_i  = idx;
    pin_in_i    = pins;
    set_busy_i  = sb;
    set_done_i  = sd;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    set_busy_i  = 1'b0;
    set_done_i  = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] op, input logic [15:0] wd);
    step(1'b1, op, cur_code, wd, 4'd0, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic iorst(input logic pol, input logic ext, input logic [5:0] code);
    step(1'b1, 3'd7, 6'h3F, 16'h0, 4'd0, {pol, ext, 8'h00, code}, 1'b0, 1'b0);
    cur_code = code;
  endtask

  task automatic mask(input logic [15:0] wd, input logic [3:0] idx);
    step(1'b1, 3'd6, 6'h15, wd, idx, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic idle(input logic sb, input logic sd);
    step(1'b0, 3'd0, 6'h0, 16'h0, 4'd0, 16'h0, sb, sd);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {pin_out_o, pin_wr_o, rsp_valid_o, busy_o, done_o, irq_o, int_dis_o},
        32'h0);
    chk("R1 config", {dev_code_o, ext_reg_en_o, polarity_o, rsp_data_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 configuration latching sweep, and busy/done cleared
    for (int p = 0; p < 2; p++) begin
      for (int e = 0; e < 2; e++) begin
        for (int c = 0; c < 64; c += 9) begin
          idle(1'b1, 1'b1);
          iorst(p[0], e[0], c[5:0]);
          chk("R2 code", dev_code_o, c);
          chk("R2 polarity", polarity_o, p);
          chk("R2 ext", ext_reg_en_o, e);
          chk("R2 busy/done cleared", {busy_o, done_o}, 0);
        end
      end
    end

    // R3 exhaustive code match sweep
    iorst(1'b1, 1'b0, 6'h2A);
    for (int c = 0; c < 64; c++) begin
      cmd(3'd2, 16'h0);
      step(1'b1, 3'd1, c[5:0], 16'h0, 4'd0, 16'h0, 1'b0, 1'b0);
      chk("R3 start match", busy_o, (c == 'h2A) ? 1 : 0);
      step(1'b1, 3'd4, c[5:0], 16'hBEEF, 4'd0, 16'h0, 1'b0, 1'b0);
      chk("R3 dout match", pin_wr_o, (c == 'h2A) ? 1 : 0);
      step(1'b1, 3'd5, c[5:0], 16'h0, 4'd0, 16'h1234, 1'b0, 1'b0);
      chk("R3 din match", rsp_valid_o, (c == 'h2A) ? 1 : 0);
    end
    chk("R3 pins held", pin_out_o, 16'hBEEF);

    // R4 / R5 polarity in both directions
    for (int p = 0; p < 2; p++) begin
      iorst(p[0], 1'b0, 6'h11);
      for (int k = 0; k < 20; k++) begin
        logic [15:0] w;
        logic [15:0] exp;
        case (k)
          16: w = 16'h0000;
          17: w = 16'hFFFF;
          18: w = 16'hA5C3;
          19: w = 16'h1234;
          default: w = 16'h8000 >> k;
        endcase
        exp = (p == 1) ? w : ~w;
        cmd(3'd4, w);
        chk("R4 pin data", pin_out_o, exp);
        chk("R4 strobe", pin_wr_o, 1);
        idle(1'b0, 1'b0);
        chk("R4 strobe one cycle", pin_wr_o, 0);
        chk("R4 pins hold", pin_out_o, exp);
        step(1'b1, 3'd5, cur_code, 16'h0, 4'd0, w, 1'b0, 1'b0);
        chk("R5 rsp data", rsp_data_o, exp);
        chk("R5 rsp valid", rsp_valid_o, 1);
        idle(1'b0, 1'b0);
        chk("R5 valid one cycle", rsp_valid_o, 0);
      end
    end

    // R6 mask-out index sweep, MSB-first numbering
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 16; k += 5) begin
        mask(16'h8000 >> k, i[3:0]);
        chk("R6 mask walking one", int_dis_o, (i == k) ? 1 : 0);
      end
      mask(~(16'h8000 >> i), i[3:0]);
      chk("R6 mask walking zero", int_dis_o, 0);
    end
    mask(16'hFFFF, 4'd3);
    chk("R6 mask set", int_dis_o, 1);
    cmd(3'd1, 16'h0);
    cmd(3'd2, 16'h0);
    idle(1'b1, 1'b1);
    iorst(1'b1, 1'b0, 6'h05);
    chk("R6 untouched by other ops", int_dis_o, 1);
    mask(16'h0000, 4'd3);
    chk("R6 mask clear", int_dis_o, 0);

    // R7 busy/done
    idle(1'b1, 1'b0);
    chk("R7 set busy", {busy_o, done_o}, 2'b10);
    idle(1'b0, 1'b1);
    chk("R7 set done", {busy_o, done_o}, 2'b11);
    cmd(3'd1, 16'h0);
    chk("R7 start", {busy_o, done_o}, 2'b10);
    cmd(3'd2, 16'h0);
    chk("R7 clear", {busy_o, done_o}, 2'b00);

    // R8 command priority over same-cycle peripheral pulses
    step(1'b1, 3'd2, cur_code, 16'h0, 4'd0, 16'h0, 1'b1, 1'b1);
    chk("R8 clear wins", {busy_o, done_o}, 2'b00);
    step(1'b1, 3'd1, cur_code, 16'h0, 4'd0, 16'h0, 1'b1, 1'b1);
    chk("R8 start wins", {busy_o, done_o}, 2'b10);
    step(1'b1, 3'd7, 6'h00, 16'h0, 4'd0, {2'b10, 8'h00, 6'h05}, 1'b1, 1'b1);
    chk("R8 iorst wins", {busy_o, done_o}, 2'b00);

    // R9 skip status for all combinations
    for (int s = 0; s < 4; s++) begin
      cmd(3'd2, 16'h0);
      idle(s[1], s[0]);
      cmd(3'd3, 16'h0);
      chk("R9 skip word", rsp_data_o, {s[1], s[0], 14'b0});
      chk("R9 skip valid", rsp_valid_o, 1);
    end
    cmd(3'd2, 16'h0);
    step(1'b1, 3'd3, cur_code, 16'h0, 4'd0, 16'h0, 1'b1, 1'b1);
    chk("R9 skip reports prior value", rsp_data_o, 16'h0);

    // R10 interrupt request
    cmd(3'd2, 16'h0);
    chk("R10 irq idle", irq_o, 0);
    idle(1'b0, 1'b1);
    chk("R10 irq on done rise", irq_o, 1);
    idle(1'b0, 1'b1);
    chk("R10 irq held", irq_o, 1);
    cmd(3'd2, 16'h0);
    chk("R10 irq cleared", irq_o, 0);
    idle(1'b0, 1'b1);
    cmd(3'd1, 16'h0);
    chk("R10 start clears irq", irq_o, 0);
    idle(1'b0, 1'b1);
    mask(16'hFFFF, 4'd0);
    chk("R10 disable drops irq", {irq_o, int_dis_o}, 2'b01);
    cmd(3'd2, 16'h0);
    idle(1'b0, 1'b1);
    chk("R10 masked done no irq", {irq_o, done_o}, 2'b01);
    mask(16'h0000, 4'd0);
    cmd(3'd2, 16'h0);
    idle(1'b0, 1'b1);
    chk("R10 re-enabled irq", irq_o, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule